// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sits between a CPU register port and the analog half of a 12-bit successive-approximation converter. Software programs two control registers: one for the start handshake, the enable, the result alignment and the external channel, and one for the internal source and the conversion clock rate. The block then binary-searches the input one bit at a time. It drives a trial code to an external DAC and reads back a single comparator bit. The finished code goes into a result register, which software reads through two 8-bit data registers in either left or right alignment.

A conversion is started by a handshake on a software bit. Raising the start bit clears the converter and drops busy. Lowering it again launches a new conversion and raises busy. The conversion clock is a clock-enable pulse derived from the system clock, with a power-of-two divide ratio from 1 to 128. The analog multiplexer, the comparator, the DAC and the reference amplifier are outside this block and appear only as ports.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, `dac_code`, `chan_sel`, `src_sel` and `conv_done` are 0, and busy is 0.
- R2: Address 0 reads {start[7], busy[6], enable[5], format[4], 0[3], channel[2:0]}. Address 1 reads {source[7:5], 00[4:3], rate[2:0]}. Writes to bit 6 of address 0 and to the unused bits have no effect. Addresses 2 (data high) and 3 (data low) are read-only.
- R3: A write that changes the start bit from 0 to 1 aborts any conversion and clears busy. A write that changes it from 1 to 0 while enabled launches a conversion, and busy reads 1 from the next cycle on.
- R4: With rate field N, busy reads 1 for exactly 13·2^N system cycles after the launching write edge. `conv_done` is high for exactly the one cycle in which busy first reads 0 again.
- R5: Each of the 12 steps, from the MSB down, keeps its trial bit when `cmp_in` is 1, meaning the input is at or above `dac_code`, and clears it otherwise. For an input level V from 0 to 4095 the result is V.
- R6: With format 0, data high = result[11:4] and data low = {result[3:0], 0000}. With format 1, data high = {0000, result[11:8]} and data low = result[7:0].
- R7: `chan_sel` equals the channel field of address 0 as a binary code.
- R8: `src_sel` is one-hot. Source code 1, 2 and 3 drive bits 0, 1 and 2 (supply, supply/2, supply/4). Codes 5, 6 and 7 drive bits 3, 4 and 5 (reference, reference/2, reference/4). Codes 0 and 4 drive all zeros.
- R9: While enable is 0, start edges are ignored, busy reads 0 and `dac_code` is 0. Clearing enable during a conversion aborts it.
- R10: The data registers change only when a conversion completes. An aborted conversion leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address (0 ctrl, 1 config, 2 data high, 3 data low) |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| dac_code | output | 12 | Trial code to the DAC |
| chan_sel | output | 3 | External channel select |
| src_sel | output | 6 | One-hot internal source select |
| conv_done | output | 1 | One-cycle completion pulse |

## Verification
A launching write takes effect at its clock edge, so busy reads 1 from the next cycle on. The bench then counts cycles while busy is high and expects exactly 13·2^N before busy falls. It samples `conv_done` in the cycle where busy falls and again one cycle later, and reads the data registers only after that. Register reads are combinational, so readback, select outputs and the effect of an abort are sampled one cycle after the write, between clock edges.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        SAR_IDLE  = 2'd0,
        SAR_RUN   = 2'd1,
        SAR_LATCH = 2'd2
    } sar_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_DHI  = 2'd2;
    localparam logic [1:0] ADDR_DLO  = 2'd3;

    localparam int BIT_START = 7;
    localparam int BIT_BUSY  = 6;
    localparam int BIT_EN    = 5;
    localparam int BIT_FMT   = 4;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);
    localparam int CNT_W = (1 << DIV_SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] lim;

    always_comb begin
        one_sh = (CNT_W+1)'(1) << div_sel;
        lim    = CNT_W'(one_sh - 1'b1);
        tick   = run && (st_q.cnt >= lim);
        st_d   = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the count never runs past the largest ratio
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
    import adc_ctrl_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             abort,
    input  logic             tick,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        sar_state_e       state;
        logic [RES_W-1:0] code;
        logic [RES_W-1:0] mask;
        logic [RES_W-1:0] res;
        logic             done;
    } sar_st_t;

    sar_st_t st_d, st_q;
    logic [RES_W-1:0] kept;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        kept      = cmp_in ? st_q.code : (st_q.code & ~st_q.mask);
        if (abort) begin
            st_d.state = SAR_IDLE;
            st_d.code  = '0;
            st_d.mask  = '0;
        end else if (launch) begin
            st_d.state = SAR_RUN;
            st_d.code  = TOP_BIT;
            st_d.mask  = TOP_BIT;
        end else if (tick) begin
            case (st_q.state)
                SAR_RUN: begin
                    if (st_q.mask[0]) begin
                        st_d.state = SAR_LATCH;
                        st_d.mask  = '0;
                        st_d.code  = kept;
                    end else begin
                        st_d.mask = st_q.mask >> 1;
                        st_d.code = kept | (st_q.mask >> 1);
                    end
                end
                SAR_LATCH: begin
                    st_d.res   = st_q.code;
                    st_d.done  = 1'b1;
                    st_d.state = SAR_IDLE;
                    st_d.code  = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: SAR_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign dac_code = st_q.code;
    assign busy     = (st_q.state != SAR_IDLE);
    assign done     = st_q.done;
    assign result   = st_q.res;

    // R4: completion pulse lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: stored result moves only with a completion
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
    // R5: at most one trial bit is under test
    a_r5_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.mask));
    // R5: a running search always has a bit under test
    a_r5_run_has_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SAR_RUN) |-> (st_q.mask != '0));

endmodule

// File: rtl/adc_result_pack.sv
module adc_result_pack #(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] result,
    input  logic             right_align,
    output logic [7:0]       data_hi,
    output logic [7:0]       data_lo
);
    localparam int PAD_W = 16 - RES_W;
    localparam int LOW_W = RES_W - 8;

    always_comb begin
        if (right_align) begin
            data_hi = {{PAD_W{1'b0}}, result[RES_W-1:8]};
            data_lo = result[7:0];
        end else begin
            data_hi = result[RES_W-1 -: 8];
            data_lo = {result[LOW_W-1:0], {PAD_W{1'b0}}};
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int DIV_SEL_W = 3,
    parameter int CH_W      = 3,
    parameter int SRC_W     = 3,
    parameter int SRC_N     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_we,
    output logic [7:0]       reg_rdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [CH_W-1:0]  chan_sel,
    output logic [SRC_N-1:0] src_sel,
    output logic             conv_done
);
    typedef struct packed {
        logic                 start;
        logic                 en;
        logic                 fmt;
        logic [CH_W-1:0]      chan;
        logic [SRC_W-1:0]     src;
        logic [DIV_SEL_W-1:0] div;
    } regs_t;

    regs_t regs_d, regs_q;
    logic wr_ctrl, wr_cfg, start_rise, start_fall, abort, launch;
    logic busy, tick;
    logic [RES_W-1:0] result;
    logic [7:0] data_hi, data_lo;
    logic unused_wbit3;

    assign unused_wbit3 = reg_wdata[3];

    always_comb begin
        wr_ctrl    = reg_we && (reg_addr == ADDR_CTRL);
        wr_cfg     = reg_we && (reg_addr == ADDR_CFG);
        start_rise = wr_ctrl &&  reg_wdata[BIT_START] && !regs_q.start;
        start_fall = wr_ctrl && !reg_wdata[BIT_START] &&  regs_q.start;
        regs_d     = regs_q;
        if (wr_ctrl) begin
            regs_d.start = reg_wdata[BIT_START];
            regs_d.en    = reg_wdata[BIT_EN];
            regs_d.fmt   = reg_wdata[BIT_FMT];
            regs_d.chan  = reg_wdata[CH_W-1:0];
        end
        if (wr_cfg) begin
            regs_d.src = reg_wdata[7 -: SRC_W];
            regs_d.div = reg_wdata[DIV_SEL_W-1:0];
        end
        abort  = start_rise || !regs_d.en;
        launch = start_fall && regs_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    adc_clk_div #(.DIV_SEL_W(DIV_SEL_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .div_sel (regs_q.div),
        .tick    (tick)
    );

    adc_sar_engine #(.RES_W(RES_W)) sar_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .abort    (abort),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .busy     (busy),
        .done     (conv_done),
        .result   (result)
    );

    adc_result_pack #(.RES_W(RES_W)) pack_i (
        .result      (result),
        .right_align (regs_q.fmt),
        .data_hi     (data_hi),
        .data_lo     (data_lo)
    );

    always_comb begin
        src_sel = '0;
        case (regs_q.src)
            3'd1: src_sel[0] = 1'b1;
            3'd2: src_sel[1] = 1'b1;
            3'd3: src_sel[2] = 1'b1;
            3'd5: src_sel[3] = 1'b1;
            3'd6: src_sel[4] = 1'b1;
            3'd7: src_sel[5] = 1'b1;
            default: ;
        endcase
    end

    assign chan_sel = regs_q.chan;

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {regs_q.start, busy, regs_q.en, regs_q.fmt,
                                    1'b0, regs_q.chan};
            ADDR_CFG:  reg_rdata = {regs_q.src, 2'b00, regs_q.div};
            ADDR_DHI:  reg_rdata = data_hi;
            default:   reg_rdata = data_lo;
        endcase
    end

    // R8: never more than one internal source
    a_r8_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_sel));
    // R9: disabled controller is idle
    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.en |-> !busy);
    // R9: disabled controller drives a zero trial code
    a_r9_dac_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.en |-> (dac_code == '0));
    // R3: busy only rises after a falling start edge
    a_r3_busy_needs_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_fall));

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic [2:0]  chan_sel;
    logic [5:0]  src_sel;
    logic        conv_done;
    logic [11:0] vin = '0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;
    assign cmp_in = (vin >= dac_code);

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .chan_sel(chan_sel), .src_sel(src_sel),
        .conv_done(conv_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // full conversion; returns after completion with data checked
    task automatic convert(input logic [11:0] v, input int div, input logic fmt);
        logic [7:0] d;
        int n;
        int exp_hi, exp_lo;
        vin = v;
        wr(2'd1, 8'(div));
        wr(2'd0, {1'b1, 1'b0, 1'b1, fmt, 4'b0000});
        wr(2'd0, {1'b0, 1'b0, 1'b1, fmt, 4'b0000});
        n = 0;
        rd(2'd0, d);
        while (d[6] && n < 5000) begin
            n++;
            @(negedge clk);
            rd(2'd0, d);
        end
        chk("R4 busy length", n, 13 << div);
        chk("R4 done high", int'(conv_done), 1);
        @(negedge clk);
        chk("R4 done single", int'(conv_done), 0);
        if (fmt) begin exp_hi = v >> 8; exp_lo = v & 255; end
        else     begin exp_hi = v >> 4; exp_lo = (v & 15) << 4; end
        rd(2'd2, d); chk("R5 R6 data high", int'(d), exp_hi);
        rd(2'd3, d); chk("R5 R6 data low", int'(d), exp_lo);
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] hold_hi, hold_lo;
        int exp_src;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); chk("R1 reset reg", int'(d), 0);
        end
        chk("R1 reset dac", int'(dac_code), 0);
        chk("R1 reset chan", int'(chan_sel), 0);
        chk("R1 reset src", int'(src_sel), 0);
        chk("R1 reset done", int'(conv_done), 0);

        // R2 readback with unused bits
        wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 ctrl readback", int'(d), 8'hB7);
        wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 cfg readback", int'(d), 8'hE7);
        wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 data high read-only", int'(d), 0);
        wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 data low read-only", int'(d), 0);

        // R7 channel select sweep
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, 8'(c) | 8'h20);
            chk("R7 chan_sel", int'(chan_sel), c);
        end
        // R8 internal source sweep
        for (int s = 0; s < 8; s++) begin
            wr(2'd1, 8'(s << 5));
            if (s == 0 || s == 4) exp_src = 0;
            else if (s < 4)       exp_src = 1 << (s - 1);
            else                  exp_src = 1 << (s - 2);
            chk("R8 src_sel", int'(src_sel), exp_src);
            rd(2'd1, d); chk("R2 cfg source field", int'(d), s << 5);
        end

        // R9 start edges ignored while disabled
        wr(2'd0, 8'h80);
        wr(2'd0, 8'h00);
        for (int k = 0; k < 4; k++) begin
            rd(2'd0, d);
            chk("R9 disabled busy", int'(d[6]), 0);
            chk("R9 disabled dac", int'(dac_code), 0);
            @(negedge clk);
        end

        // R4 R5 R6 sweep over every rate and both formats
        for (int dv = 0; dv < 8; dv++) begin
            convert(12'h000, dv, dv[0]);
            convert(12'hFFF, dv, !dv[0]);
            convert(12'hA5C, dv, 1'b0);
            convert(12'(dv * 517 + 3), dv, 1'b1);
        end
        // R5 near-exhaustive level sweep at full rate
        for (int v = 0; v < 4096; v += 37) convert(12'(v), 0, v[0]);

        // R3 busy from the cycle after launch, R10 data held, R9 abort
        convert(12'h123, 0, 1'b1);
        hold_hi = 8'h01; hold_lo = 8'h23;
        vin = 12'hFFF;
        wr(2'd1, 8'd3);
        wr(2'd0, 8'hB0);
        wr(2'd0, 8'h30);
        rd(2'd0, d); chk("R3 busy after launch", int'(d[6]), 1);
        repeat (20) @(negedge clk);
        rd(2'd2, d); chk("R10 data high held", int'(d), hold_hi);
        rd(2'd3, d); chk("R10 data low held", int'(d), hold_lo);
        wr(2'd0, 8'h10);
        rd(2'd0, d); chk("R9 abort busy", int'(d[6]), 0);
        chk("R9 abort dac", int'(dac_code), 0);
        repeat (120) @(negedge clk);
        rd(2'd2, d); chk("R10 abort data high", int'(d), hold_hi);
        rd(2'd3, d); chk("R10 abort data low", int'(d), hold_lo);

        // R3 rising start edge aborts
        wr(2'd0, 8'hB0);
        wr(2'd0, 8'h30);
        repeat (10) @(negedge clk);
        rd(2'd0, d); chk("R3 running", int'(d[6]), 1);
        wr(2'd0, 8'hB0);
        rd(2'd0, d); chk("R3 rise clears busy", int'(d[6]), 0);
        repeat (120) @(negedge clk);
        rd(2'd3, d); chk("R10 rise abort data", int'(d), hold_lo);
        chk("R4 no done after abort", int'(conv_done), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule